// File: doc/BRIEF.md
# Peak-Hold Telemetry Register Bank

This block tracks the running maximum of three 16-bit telemetry channels: output voltage, output current and die temperature. Each channel receives measured samples on a valid-qualified input. The voltage channel has two sources, a raw instantaneous sample and an averaged one. A mode input selects which source feeds the peak. Commanded setpoints never reach this block, so only measured values can raise a peak.

The host reaches the bank through a single-cycle register-write port and a combinational read port. A write to a channel either clears its peak or preloads a baseline that later samples must beat. The voltage and current peaks are unsigned and are cleared by writing zero. The temperature peak is signed. Writing the all-ones code to it resets it to the most negative value, and any other value becomes its baseline.

The sample inputs use valid-only flow with no back-pressure. A producer never stalls, and the bank consumes every strobe in the cycle it is presented. When a host write targets the same channel in that cycle, the strobe is dropped. Peaks are registered and appear on the outputs and the read port one clock after the strobe or write.

Top module: `peak_hold_bank`

## Requirements
- R1: After reset, all three peaks read 0x0000.
- R2: For voltage and current, a valid sample that is unsigned-greater than the stored peak replaces it. A sample that is equal or smaller leaves the peak unchanged.
- R3: For temperature, samples are compared as signed two's-complement 16-bit values, and a signed-greater sample replaces the peak.
- R4: A host write of 0x0000 to the voltage (select 0) or current (select 1) peak clears it to zero.
- R5: A host write of any nonzero value to the voltage or current peak stores that value as the new peak, and only later samples that exceed it update it.
- R6: A host write of 0xFFFF to the temperature peak (select 2) loads 0x8000. Any other written value is stored as the temperature baseline.
- R7: When `avg_mode` is 1, the voltage peak follows only the averaged stream (`vavg_valid`/`vavg_data`) and raw voltage strobes have no effect. When `avg_mode` is 0, only the raw stream counts.
- R8: When a host write and a sample strobe hit the same channel in one cycle, the write result is stored and the sample is discarded. Samples on other channels in that cycle are still applied.
- R9: Updates are registered, so a new peak is visible one clock after its strobe or write. `rd_sel` values 0, 1 and 2 return the voltage, current and temperature peak, and value 3 returns 0x0000. A write with `wr_sel` = 3 changes no peak.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avg_mode | input | 1 | 1: voltage peak tracks the averaged stream |
| vraw_valid | input | 1 | Raw voltage sample strobe |
| vraw_data | input | 16 | Raw voltage sample (unsigned) |
| vavg_valid | input | 1 | Averaged voltage sample strobe |
| vavg_data | input | 16 | Averaged voltage sample (unsigned) |
| cur_valid | input | 1 | Current sample strobe |
| cur_data | input | 16 | Current sample (unsigned) |
| tmp_valid | input | 1 | Temperature sample strobe |
| tmp_data | input | 16 | Temperature sample (signed) |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 voltage, 1 current, 2 temperature, 3 none |
| wr_data | input | 16 | Host write value |
| rd_sel | input | 2 | Read select: 0 voltage, 1 current, 2 temperature, 3 zero |
| rd_data | output | 16 | Selected peak |
| vout_peak | output | 16 | Voltage peak |
| iout_peak | output | 16 | Current peak |
| temp_peak | output | 16 | Temperature peak |

## Verification
A host write and a sample strobe can reach the same channel in the same cycle, and the bank must let the write win. The random phase drives writes often enough that they regularly overlap strobes on the targeted channel and on the other channels. Directed cycles also send a write together with a sample that would otherwise have raised the peak. The bench model applies the write and drops that channel's sample. The peak seen one clock later must equal the written value, while the other channels show their own sample updates.

// File: rtl/peak_pkg.sv
package peak_pkg;
  localparam int NUM_CH  = 3;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    CH_VOUT = 2'd0,
    CH_IOUT = 2'd1,
    CH_TEMP = 2'd2,
    CH_NONE = 2'd3
  } ch_sel_e;
endpackage

// File: rtl/peak_vsrc.sv
// Chooses which voltage stream feeds the voltage peak.
module peak_vsrc #(
  parameter int DW = 16
) (
  input  logic          avg_mode,
  input  logic          raw_valid,
  input  logic [DW-1:0] raw_data,
  input  logic          avg_valid,
  input  logic [DW-1:0] avg_data,
  output logic          sel_valid,
  output logic [DW-1:0] sel_data
);
  always_comb begin
    if (avg_mode) begin
      sel_valid = avg_valid;
      sel_data  = avg_data;
    end else begin
      sel_valid = raw_valid;
      sel_data  = raw_data;
    end
  end
endmodule

// File: rtl/peak_channel.sv
// One running-maximum register with clear/preload write semantics.
module peak_channel #(
  parameter int          DW         = 16,
  parameter bit          SIGNED_CMP = 1'b0,
  parameter logic [DW-1:0] CLEAR_CODE = '0,
  parameter logic [DW-1:0] FLOOR_VAL  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] peak
);
  function automatic logic above(input logic [DW-1:0] a, input logic [DW-1:0] b);
    if (SIGNED_CMP) return $signed(a) > $signed(b);
    else            return a > b;
  endfunction

  logic          beats;
  logic [DW-1:0] wr_value;

  assign beats    = above(smp_data, peak);
  assign wr_value = (wr_data == CLEAR_CODE) ? FLOOR_VAL : wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n)                 peak <= '0;
    else if (wr_hit)            peak <= wr_value;
    else if (smp_valid && beats) peak <= smp_data;
  end

  // R2 / R3: a winning sample is captured one clock later
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !wr_hit && above(smp_data, peak)) |=> (peak == $past(smp_data)));

  // R2 / R3: without a write the peak never falls
  p_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit) |=> !above($past(peak), peak));

  // R9: idle cycles hold the peak
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !smp_valid) |=> $stable(peak));

  // R8: a write wins over a colliding sample
  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data != CLEAR_CODE) |=> (peak == $past(wr_data)));

  // R4 / R6: clear code loads the floor value
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data == CLEAR_CODE) |=> (peak == FLOOR_VAL));
endmodule

// File: rtl/peak_rdmux.sv
// Read-port selector; out-of-range selects return zero.
module peak_rdmux #(
  parameter int DW     = 16,
  parameter int NCH    = 3,
  parameter int SW     = 2
) (
  input  logic [NCH-1:0][DW-1:0] peaks,
  input  logic [SW-1:0]          sel,
  output logic [DW-1:0]          data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel == SW'(i)) data = peaks[i];
    end
  end
endmodule

// File: rtl/peak_hold_bank.sv
module peak_hold_bank
  import peak_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          avg_mode,
  input  logic          vraw_valid,
  input  logic [DW-1:0] vraw_data,
  input  logic          vavg_valid,
  input  logic [DW-1:0] vavg_data,
  input  logic          cur_valid,
  input  logic [DW-1:0] cur_data,
  input  logic          tmp_valid,
  input  logic [DW-1:0] tmp_data,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] vout_peak,
  output logic [DW-1:0] iout_peak,
  output logic [DW-1:0] temp_peak
);
  localparam logic [DW-1:0] TEMP_CLEAR = '1;
  localparam logic [DW-1:0] TEMP_FLOOR = {1'b1, {(DW-1){1'b0}}};

  logic                     vsel_valid;
  logic [DW-1:0]            vsel_data;
  logic [NUM_CH-1:0]        ch_valid;
  logic [NUM_CH-1:0][DW-1:0] ch_data;
  logic [NUM_CH-1:0][DW-1:0] ch_peak;

  peak_vsrc #(.DW(DW)) u_vsrc (
    .avg_mode  (avg_mode),
    .raw_valid (vraw_valid),
    .raw_data  (vraw_data),
    .avg_valid (vavg_valid),
    .avg_data  (vavg_data),
    .sel_valid (vsel_valid),
    .sel_data  (vsel_data)
  );

  assign ch_valid = {tmp_valid, cur_valid, vsel_valid};
  assign ch_data  = {tmp_data,  cur_data,  vsel_data};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam bit          IS_TEMP = (g == int'(CH_TEMP));
    localparam logic [DW-1:0] CLR   = IS_TEMP ? TEMP_CLEAR : '0;
    localparam logic [DW-1:0] FLR   = IS_TEMP ? TEMP_FLOOR : '0;
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(g));

    peak_channel #(
      .DW(DW), .SIGNED_CMP(IS_TEMP), .CLEAR_CODE(CLR), .FLOOR_VAL(FLR)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (ch_valid[g]),
      .smp_data  (ch_data[g]),
      .wr_hit    (hit),
      .wr_data   (wr_data),
      .peak      (ch_peak[g])
    );
  end

  peak_rdmux #(.DW(DW), .NCH(NUM_CH), .SW(SEL_W)) u_rd (
    .peaks (ch_peak),
    .sel   (rd_sel),
    .data  (rd_data)
  );

  assign vout_peak = ch_peak[CH_VOUT];
  assign iout_peak = ch_peak[CH_IOUT];
  assign temp_peak = ch_peak[CH_TEMP];

  // R7: in averaged mode a cycle without an averaged strobe or write keeps the voltage peak
  p_avg_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (avg_mode && !vavg_valid && !(wr_en && wr_sel == CH_VOUT)) |=> $stable(vout_peak));

  // R9: a write to no channel leaves every peak when no samples arrive
  p_none_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == CH_NONE && !vraw_valid && !vavg_valid && !cur_valid && !tmp_valid)
    |=> ($stable(vout_peak) && $stable(iout_peak) && $stable(temp_peak)));
endmodule

// File: tb/test_peak_hold_bank.sv
module test_peak_hold_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        avg_mode = 1'b0;
  logic        vraw_valid = 1'b0, vavg_valid = 1'b0, cur_valid = 1'b0, tmp_valid = 1'b0;
  logic [15:0] vraw_data = '0, vavg_data = '0, cur_data = '0, tmp_data = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0, rd_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, vout_peak, iout_peak, temp_peak;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_peak [3];

  always #2 clk = ~clk;

  peak_hold_bank i_peak_hold_bank (
    .clk(clk), .rst_n(rst_n), .avg_mode(avg_mode),
    .vraw_valid(vraw_valid), .vraw_data(vraw_data),
    .vavg_valid(vavg_valid), .vavg_data(vavg_data),
    .cur_valid(cur_valid), .cur_data(cur_data),
    .tmp_valid(tmp_valid), .tmp_data(tmp_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .vout_peak(vout_peak), .iout_peak(iout_peak), .temp_peak(temp_peak)
  );

  function automatic logic [15:0] next_peak(input int ch, input logic [15:0] cur,
      input logic hit, input logic [15:0] wd, input logic v, input logic [15:0] s);
    logic gt;
    if (hit) begin
      if (ch == 2 && wd == 16'hFFFF) return 16'h8000;
      return wd;
    end
    if (!v) return cur;
    gt = (ch == 2) ? ($signed(s) > $signed(cur)) : (s > cur);
    return gt ? s : cur;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    vraw_valid = 0; vavg_valid = 0; cur_valid = 0; tmp_valid = 0; wr_en = 0;
  endtask

  // advance one clock, update the model from the driven inputs, compare
  task automatic tick(input string req);
    logic vv;
    logic [15:0] vd;
    logic [15:0] exp_rd;
    vv = avg_mode ? vavg_valid : vraw_valid;
    vd = avg_mode ? vavg_data  : vraw_data;
    @(posedge clk);
    #1;
    m_peak[0] = next_peak(0, m_peak[0], wr_en && wr_sel == 2'd0, wr_data, vv, vd);
    m_peak[1] = next_peak(1, m_peak[1], wr_en && wr_sel == 2'd1, wr_data, cur_valid, cur_data);
    m_peak[2] = next_peak(2, m_peak[2], wr_en && wr_sel == 2'd2, wr_data, tmp_valid, tmp_data);
    exp_rd = (rd_sel == 2'd3) ? 16'h0000 : m_peak[rd_sel];
    check(req, vout_peak, m_peak[0]);
    check(req, iout_peak, m_peak[1]);
    check(req, temp_peak, m_peak[2]);
    check({req, " rd"}, rd_data, exp_rd);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED1;
    void'($urandom(seed));
    for (int i = 0; i < 3; i++) m_peak[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    // R1: reset state
    check("R1 vout", vout_peak, 16'h0000);
    check("R1 iout", iout_peak, 16'h0000);
    check("R1 temp", temp_peak, 16'h0000);

    // R2: unsigned growth, smaller ignored
    vraw_valid = 1; vraw_data = 16'h9000; cur_valid = 1; cur_data = 16'h0040;
    rd_sel = 0; tick("R2");
    vraw_data = 16'h1000; cur_data = 16'h0030; rd_sel = 1; tick("R2");
    idle();
    // R4: zero write clears current
    wr_en = 1; wr_sel = 1; wr_data = 16'h0000; tick("R4");
    check("R4 clear", iout_peak, 16'h0000);
    // R5: baseline preload then smaller sample ignored, larger taken
    wr_sel = 0; wr_data = 16'hA000; tick("R5");
    idle(); vraw_valid = 1; vraw_data = 16'h9FFF; tick("R5");
    check("R5 below", vout_peak, 16'hA000);
    vraw_data = 16'hA001; tick("R5");
    // R6 / R3: temperature reset code and signed compare
    idle(); wr_en = 1; wr_sel = 2; wr_data = 16'hFFFF; rd_sel = 2; tick("R6");
    check("R6 floor", temp_peak, 16'h8000);
    idle(); tmp_valid = 1; tmp_data = 16'hFF00; tick("R3");
    check("R3 neg", temp_peak, 16'hFF00);
    tmp_data = 16'h0010; tick("R3");
    tmp_data = 16'hFFF0; tick("R3");
    check("R3 signed", temp_peak, 16'h0010);
    idle(); wr_en = 1; wr_sel = 2; wr_data = 16'h7F00; tick("R6");
    // R7: averaged mode ignores raw stream
    idle(); avg_mode = 1; vraw_valid = 1; vraw_data = 16'hFFFE; tick("R7");
    check("R7 raw ignored", vout_peak, 16'hA001);
    vavg_valid = 1; vavg_data = 16'hB000; tick("R7");
    idle(); avg_mode = 0; vavg_valid = 1; vavg_data = 16'hC000; tick("R7");
    check("R7 avg ignored", vout_peak, 16'hB000);
    // R8: write and sample collide on voltage; current still updates
    idle(); vraw_valid = 1; vraw_data = 16'hF000; cur_valid = 1; cur_data = 16'h0500;
    wr_en = 1; wr_sel = 0; wr_data = 16'h0005; rd_sel = 0; tick("R8");
    check("R8 write wins", vout_peak, 16'h0005);
    check("R8 other ch", iout_peak, 16'h0500);
    // R9: select 3 writes nothing, reads zero
    idle(); wr_en = 1; wr_sel = 3; wr_data = 16'hFFFF; rd_sel = 3; tick("R9");
    check("R9 rd none", rd_data, 16'h0000);

    // random phase
    for (int n = 0; n < 2000; n++) begin
      avg_mode   = ($urandom % 4) == 0;
      vraw_valid = $urandom % 2; vraw_data = 16'($urandom);
      vavg_valid = $urandom % 2; vavg_data = 16'($urandom);
      cur_valid  = $urandom % 2; cur_data  = 16'($urandom);
      tmp_valid  = $urandom % 2; tmp_data  = 16'($urandom);
      wr_en      = ($urandom % 8) == 0;
      wr_sel     = 2'($urandom);
      case ($urandom % 4)
        0: wr_data = 16'h0000;
        1: wr_data = 16'hFFFF;
        default: wr_data = 16'($urandom);
      endcase
      rd_sel = 2'($urandom);
      tick(wr_en ? "R8" : "R2");
    end
    idle();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule